// File: doc/BRIEF.md
# Timer Interrupt Flag and Vector Unit

This block keeps the interrupt flags of a timer that has one primary compare channel, a parameterised number of secondary compare channels and a counter overflow event. Single-cycle event strobes from the timer datapath set the flags. A per-source enable register decides which flags drive the two request outputs. The primary channel has its own request line, and its flag clears itself when that request is acknowledged. The secondary channels and the overflow share a second request line.

The shared sources are served through a read-only vector. The vector always shows a code for the highest-priority pending, enabled shared source. A read strobe consumes that one source and clears its flag; every other flag is left as it was. Software may also overwrite the whole flag register directly. A flag that is never cleared keeps its request asserted, so the handler runs again.

Top module: `tmr_irq_vec`

## Requirements
- R1: After reset all flags and enables are 0, both requests are low and the vector reads 0.
- R2: An event strobe sets its flag at the next clock edge whether or not the source is enabled. In `flag_q`, bit 0 is the primary channel, bit k (1..N_SEC) is secondary channel k, and bit N_SEC+1 is the overflow. The enable vector uses the same bit positions.
- R3: `irq_pri` equals flag bit 0 AND enable bit 0. `irq_shared` is the OR of the enabled shared flags. Both requests stay high for as long as the enabled flag stays set.
- R4: `pri_ack` clears the primary flag at the next edge and leaves all shared flags unchanged.
- R5: `vec_rdata` is 0 when no enabled shared flag is set. Otherwise it is 2·k for secondary channel k, or 2·(N_SEC+1) for the overflow. The lowest channel number has the highest priority and the overflow has the lowest. Disabled flags are not reported.
- R6: A `vec_rd` strobe while `vec_rdata` is non-zero clears exactly the reported flag at the next edge.
- R7: A `vec_rd` strobe while `vec_rdata` is 0 changes no flag.
- R8: `flag_wr` replaces the flag register with `flag_wdata` at the next edge, which can both set and clear flags. It takes precedence over clears from an acknowledge or a vector read in the same cycle.
- R9: If an event strobe and any clear (acknowledge, vector read or flag write) hit the same flag in the same cycle, the flag ends up set.
- R10: `en_wr` replaces the enable register with `en_wdata`. The requests and the vector follow the new enables from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_pri | input | 1 | Primary compare event strobe |
| evt_sec | input | N_SEC | Secondary compare event strobes, bit k-1 is channel k |
| evt_ovf | input | 1 | Counter overflow event strobe |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | N_SEC+2 | Enable register write data |
| flag_wr | input | 1 | Flag register write strobe |
| flag_wdata | input | N_SEC+2 | Flag register write data |
| vec_rd | input | 1 | Vector read strobe, consumes the reported source |
| pri_ack | input | 1 | Primary request acknowledge |
| vec_rdata | output | VEC_W | Vector code of the top pending shared source |
| flag_q | output | N_SEC+2 | Current flag register |
| irq_pri | output | 1 | Primary request |
| irq_shared | output | 1 | Shared request |

## Verification
A wrong flag shows at `flag_q` one cycle after the offending edge. It also shows on a request output or the vector in that same cycle whenever the source is enabled. A wrong priority choice shows up first as a wrong vector code. If a read then clears the wrong flag, the effect carries forward: the wrong source is consumed and the next read reports an unexpected code. The bench compares every output against a model on every cycle, so a fault appears in the first cycle it affects.

// File: rtl/tmr_irq_vec.sv
module tmr_irq_vec #(
  parameter int N_SEC = 4,
  localparam int NF    = N_SEC + 2,
  localparam int VEC_W = $clog2(2 * NF - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_pri,
  input  logic [N_SEC-1:0] evt_sec,
  input  logic             evt_ovf,
  input  logic             en_wr,
  input  logic [NF-1:0]    en_wdata,
  input  logic             flag_wr,
  input  logic [NF-1:0]    flag_wdata,
  input  logic             vec_rd,
  input  logic             pri_ack,
  output logic [VEC_W-1:0] vec_rdata,
  output logic [NF-1:0]    flag_q,
  output logic             irq_pri,
  output logic             irq_shared
);

  logic [NF-1:0] en_q, pend, evt_all, rd_sel, clr, flag_d;

  assign evt_all = {evt_ovf, evt_sec, evt_pri};
  assign pend    = flag_q & en_q;

  always_comb begin
    vec_rdata = '0;
    rd_sel    = '0;
    for (int i = NF - 1; i >= 1; i--) begin
      if (pend[i]) begin
        vec_rdata = VEC_W'(2 * i);
        rd_sel    = NF'(1) << i;
      end
    end
  end

  assign clr    = (vec_rd ? rd_sel : '0) | {{(NF-1){1'b0}}, pri_ack};
  assign flag_d = (flag_wr ? flag_wdata : (flag_q & ~clr)) | evt_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_wr) en_q <= en_wdata;
    end
  end

  assign irq_pri    = pend[0];
  assign irq_shared = |pend[NF-1:1];

  // R2, R9: every strobed source is set one edge later
  a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_all) |=> ((flag_q & $past(evt_all)) == $past(evt_all)));
  // R4
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_ack && !evt_pri && !flag_wr) |=> !flag_q[0]);
  // R3, R5
  a_r5_req_has_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq_shared |-> (vec_rdata != '0));
  // R6
  a_r6_one_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec_rdata != '0 && !flag_wr && !pri_ack && evt_all == '0)
      |=> ($countones(flag_q) + 1 == $countones($past(flag_q))));
  // R7
  a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec_rdata == '0 && !flag_wr && !pri_ack && evt_all == '0)
      |=> $stable(flag_q));
  // R3
  a_r3_pri_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pri |-> flag_q[0]);

endmodule

// File: tb/test_tmr_irq_vec.sv
module test_tmr_irq_vec;
  localparam int N     = 4;
  localparam int NF    = N + 2;
  localparam int VW    = $clog2(2 * NF - 1);
  localparam int T_CLK = 10;

  logic clk = 0, rst_n = 0;
  logic evt_pri = 0, evt_ovf = 0, en_wr = 0, flag_wr = 0, vec_rd = 0, pri_ack = 0;
  logic [N-1:0]  evt_sec = '0;
  logic [NF-1:0] en_wdata = '0, flag_wdata = '0;
  logic [VW-1:0] vec_rdata;
  logic [NF-1:0] flag_q;
  logic irq_pri, irq_shared;

  int n_chk = 0, n_bad = 0;
  logic [NF-1:0] m_fl = '0, m_en = '0;

  tmr_irq_vec #(.N_SEC(N)) i_tmr_irq_vec (
    .clk, .rst_n, .evt_pri, .evt_sec, .evt_ovf, .en_wr, .en_wdata,
    .flag_wr, .flag_wdata, .vec_rd, .pri_ack, .vec_rdata, .flag_q,
    .irq_pri, .irq_shared);

  always #(T_CLK/2) clk = ~clk;

  function automatic int exp_vec(logic [NF-1:0] f, logic [NF-1:0] e);
    for (int k = 1; k < NF; k++) if (f[k] && e[k]) return 2 * k;
    return 0;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " flags"}, int'(flag_q), int'(m_fl));
    chk({tag, " irq_pri"}, int'(irq_pri), int'(m_fl[0] & m_en[0]));
    chk({tag, " irq_shared"}, int'(irq_shared), int'(|(m_fl[NF-1:1] & m_en[NF-1:1])));
    chk({tag, " vec"}, int'(vec_rdata), exp_vec(m_fl, m_en));
  endtask

  task automatic cyc(string tag, logic [NF-1:0] ev, logic ew, logic [NF-1:0] ed,
                     logic fw, logic [NF-1:0] fd, logic vr, logic ak);
    int v;
    logic [NF-1:0] c;
    {evt_ovf, evt_sec, evt_pri} = ev;
    en_wr = ew; en_wdata = ed; flag_wr = fw; flag_wdata = fd; vec_rd = vr; pri_ack = ak;
    v = exp_vec(m_fl, m_en);
    c = {{(NF-1){1'b0}}, ak};
    if (vr && v != 0) c[v/2] = 1'b1;
    @(negedge clk);
    m_fl = (fw ? fd : (m_fl & ~c)) | ev;
    if (ew) m_en = ed;
    chk_all(tag);
  endtask

  initial begin
    #(T_CLK * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk_all("R1 reset");
    rst_n = 1;
    @(negedge clk);
    chk_all("R1 after release");
    // R10: enable all but channel 2 and primary
    cyc("R10 enable write", '0, 1, 6'b111011 & ~6'b000001, 0, '0, 0, 0);
    // R2: events latch even when disabled
    cyc("R2 latch", 6'b000111 | 6'b001000 | 6'b100000, 0, '0, 0, '0, 0, 0);
    chk("R3 primary disabled", int'(irq_pri), 0);
    chk("R5 ch2 disabled so ch1", int'(vec_rdata), 2);
    cyc("R6 read ch1", '0, 0, '0, 0, '0, 1, 0);
    chk("R5 skip disabled ch2", int'(vec_rdata), 6);
    cyc("R6 read ch3", '0, 0, '0, 0, '0, 1, 0);
    chk("R5 overflow code", int'(vec_rdata), 10);
    cyc("R10 enable all", '0, 1, '1, 0, '0, 0, 0);
    chk("R10 ch2 now reported", int'(vec_rdata), 4);
    chk("R3 primary now requests", int'(irq_pri), 1);
    cyc("R4 ack", '0, 0, '0, 0, '0, 0, 1);
    chk("R4 primary cleared", int'(flag_q[0]), 0);
    cyc("R9 ack vs event", 6'b000001, 0, '0, 0, '0, 0, 1);
    chk("R9 set wins on ack", int'(flag_q[0]), 1);
    cyc("R9 read vs event", 6'b000100, 0, '0, 0, '0, 1, 0);
    chk("R9 set wins on read", int'(flag_q[2]), 1);
    cyc("R8 write clear", '0, 0, '0, 1, 6'b000000, 0, 0);
    cyc("R7 empty read", '0, 0, '0, 0, '0, 1, 0);
    chk("R7 vec zero", int'(vec_rdata), 0);
    cyc("R8 write set", '0, 0, '0, 1, 6'b110001, 1, 1);
    chk("R8 write beats clears", int'(flag_q), 6'b110001);
    cyc("R9 write vs event", 6'b000010, 0, '0, 1, 6'b000000, 0, 0);
    chk("R9 set wins on write", int'(flag_q), 6'b000010);
    cyc("R3 request persists", '0, 0, '0, 0, '0, 0, 0);
    chk("R3 shared still high", int'(irq_shared), 1);
    for (int i = 0; i < 4000; i++) begin
      logic [NF-1:0] ev;
      ev = NF'($urandom) & NF'($urandom) & NF'($urandom);
      cyc("R2 R3 R5 R6 random", ev, ($urandom % 16) == 0, NF'($urandom),
          ($urandom % 32) == 0, NF'($urandom), ($urandom % 3) == 0, ($urandom % 4) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule